// File: doc/BRIEF.md
# DRAM Open-Page Tracker

The tracker records which DRAM page is currently open in every bank of every populated chip-select row, so that a memory controller can sort each incoming request into one of three kinds: a page hit (the wanted page is already open), a page miss (another page is open in that bank and must be closed first) or an empty bank (nothing is open, so an activate is enough). There are up to four rows with four banks each, so at most sixteen pages can be open at the same time. Every row has its own page size of 2, 4, 8 or 16 kB, and the page number taken from the request address moves with that size.

The classification is combinational from the request inputs. On the clock edge that accepts the request, the table is updated. An empty or missed bank then holds the new page and stays open, because the policy never auto-precharges. On a miss, only the bank that missed is replaced, and its old page is reported so it can be closed. The controller can also close a single bank, or clear a whole row in one cycle when that row receives a precharge-all or a refresh. Requests to a row whose present bit is low are flagged as errors and leave the table untouched.

Top module: `open_page_tracker`

## Requirements
- R1: After reset every entry is closed, so `openMask` reads all zero. Bit `row*4+bank` of `openMask` is set while that bank holds an open page.
- R2: A request to a populated row whose bank has no open page raises `isEmpty` in the same cycle. From the next cycle that bank is open with the request's page.
- R3: A request whose page equals the page stored for its row and bank raises `isHit` in the same cycle and leaves `openMask` and all stored pages unchanged.
- R4: A request to an open bank with a different page raises `isMiss` and `victimValid` and drives the old page on `victimPage` in the same cycle. Only that bank takes the new page. Every other entry keeps its state. `victimPage` is zero when `victimValid` is low.
- R5: The page number is `reqAddr >> (11 + code)`, where `code = rowPageSize[2*row+1:2*row]` and 0 means 2 kB, 1 means 4 kB, 2 means 8 kB, 3 means 16 kB. Two addresses inside one 16 kB block hit in a 16 kB row, and can miss in a 2 kB row.
- R6: A request to a row whose `rowPresent` bit is 0 raises only `reqError`, opens nothing and changes no state.
- R7: `closeValid` clears the single entry `closeRow`/`closeBank` on the next edge. A request installing into that same entry in the same cycle takes precedence, and the entry ends up open with the request's page.
- R8: `flushValid` clears all four banks of `flushRow` in one cycle. A request installing into that row in the same cycle takes precedence for its own bank only.
- R9: While `reqValid` is high, exactly one of `isHit`, `isMiss`, `isEmpty` and `reqError` is high. While it is low, all four are low, along with `victimValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqRow | input | 2 | Chip-select row of the request |
| reqBank | input | 2 | Bank of the request |
| reqAddr | input | 32 | Full request address |
| rowPageSize | input | 8 | Two-bit page-size code per row |
| rowPresent | input | 4 | One bit per row, high when the row is populated |
| closeValid | input | 1 | Close one bank this cycle |
| closeRow | input | 2 | Row of the bank to close |
| closeBank | input | 2 | Bank to close |
| flushValid | input | 1 | Precharge-all or refresh of one row |
| flushRow | input | 2 | Row to clear |
| isHit | output | 1 | Request page is open |
| isMiss | output | 1 | A different page is open in the bank |
| isEmpty | output | 1 | No page is open in the bank |
| reqError | output | 1 | Request addressed an unpopulated row |
| victimValid | output | 1 | `victimPage` holds a page to close |
| victimPage | output | 21 | Page number being replaced on a miss |
| openMask | output | 16 | Open state of every bank, bit row*4+bank |

## Verification
A corrupted stored page does not appear until the next request to that same bank. It then shows as a false miss with a wrong `victimPage`, or as a hit where a miss was expected, in the same combinational cycle as that request. A wrong valid bit, whether left set or cleared by mistake, shows on `openMask` one cycle after the edge that caused it. A wrong page-size shift shows at once as a wrong hit or miss on the first pair of addresses that fall in one page for the true size but not for the wrong one. For that reason, the stimulus keeps returning to a small set of pages in every bank.

// File: rtl/opt_pkg.sv
package opt_pkg;
  localparam int BANKS = 4;
  localparam int BANK_W = 2;
  localparam int SIZE_W = 2;

  typedef struct packed {
    logic install;
    logic dropBank;
    logic dropRow;
  } tblCtl_t;
endpackage

// File: rtl/opt_ctrl.sv
module opt_ctrl
  import opt_pkg::*;
#(
  parameter int ROWS = 4,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [ROWS-1:0]  rowPresent,
  input  logic             closeValid,
  input  logic             flushValid,
  input  logic             entryValid,
  input  logic             pageMatch,
  output logic             isHit,
  output logic             isMiss,
  output logic             isEmpty,
  output logic             reqError,
  output logic             victimValid,
  output tblCtl_t          ctl
);
  logic live;

  always_comb begin
    live        = reqValid && rowPresent[reqRow];
    reqError    = reqValid && !rowPresent[reqRow];
    isEmpty     = live && !entryValid;
    isHit       = live && entryValid && pageMatch;
    isMiss      = live && entryValid && !pageMatch;
    victimValid = isMiss;
    ctl.install  = isEmpty || isMiss;
    ctl.dropBank = closeValid;
    ctl.dropRow  = flushValid;
  end

  // R9
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({isHit, isMiss, isEmpty, reqError}) == 1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(ctl.install || victimValid));
endmodule

// File: rtl/opt_datapath.sv
module opt_datapath
  import opt_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int ADDR_W = 32,
  parameter int MIN_PG_LOG2 = 11,
  localparam int ROW_W = $clog2(ROWS),
  localparam int IDX_W = ROW_W + BANK_W,
  localparam int ENTRIES = ROWS * BANKS,
  localparam int PAGE_W = ADDR_W - MIN_PG_LOG2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tblCtl_t                ctl,
  input  logic [ROW_W-1:0]       reqRow,
  input  logic [BANK_W-1:0]      reqBank,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [ROWS*SIZE_W-1:0] rowPageSize,
  input  logic [ROW_W-1:0]       closeRow,
  input  logic [BANK_W-1:0]      closeBank,
  input  logic [ROW_W-1:0]       flushRow,
  output logic                   entryValid,
  output logic                   pageMatch,
  output logic [PAGE_W-1:0]      storedPage,
  output logic [ENTRIES-1:0]     openMask
);
  logic [ENTRIES-1:0]  validQ;
  logic [PAGE_W-1:0]   pageQ [ENTRIES];
  logic [IDX_W-1:0]    reqIdx;
  logic [IDX_W-1:0]    closeIdx;
  logic [SIZE_W-1:0]   sizeCode;
  logic [ADDR_W-1:0]   shifted;
  logic [PAGE_W-1:0]   reqPage;

  always_comb begin
    reqIdx   = {reqRow, reqBank};
    closeIdx = {closeRow, closeBank};
    sizeCode = rowPageSize[reqRow*SIZE_W +: SIZE_W];
    shifted  = (reqAddr >> MIN_PG_LOG2) >> sizeCode;
    reqPage  = shifted[PAGE_W-1:0];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
    localparam logic [ROW_W-1:0] MY_ROW = ROW_W'(e / BANKS);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
        pageQ[e]  <= '0;
      end else if (ctl.install && reqIdx == MY_IDX) begin
        validQ[e] <= 1'b1;
        pageQ[e]  <= reqPage;
      end else if ((ctl.dropBank && closeIdx == MY_IDX) ||
                   (ctl.dropRow && flushRow == MY_ROW)) begin
        validQ[e] <= 1'b0;
      end
    end
  end

  always_comb begin
    entryValid = validQ[reqIdx];
    storedPage = pageQ[reqIdx];
    pageMatch  = storedPage == reqPage;
    openMask   = validQ;
  end

  // R2
  install_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.install |=> openMask[$past(reqIdx)]);

  // R7
  close_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dropBank && !(ctl.install && reqIdx == closeIdx))
      |=> !openMask[$past(closeIdx)]);

  // R8
  flush_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dropRow && !(ctl.install && reqRow == flushRow))
      |=> ((openMask >> {$past(flushRow), 2'b00}) & ENTRIES'(4'hF)) == '0);
endmodule

// File: rtl/open_page_tracker.sv
module open_page_tracker
  import opt_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int ADDR_W = 32,
  parameter int MIN_PG_LOG2 = 11,
  localparam int ROW_W = $clog2(ROWS),
  localparam int ENTRIES = ROWS * BANKS,
  localparam int PAGE_W = ADDR_W - MIN_PG_LOG2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ROW_W-1:0]       reqRow,
  input  logic [BANK_W-1:0]      reqBank,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [ROWS*SIZE_W-1:0] rowPageSize,
  input  logic [ROWS-1:0]        rowPresent,
  input  logic                   closeValid,
  input  logic [ROW_W-1:0]       closeRow,
  input  logic [BANK_W-1:0]      closeBank,
  input  logic                   flushValid,
  input  logic [ROW_W-1:0]       flushRow,
  output logic                   isHit,
  output logic                   isMiss,
  output logic                   isEmpty,
  output logic                   reqError,
  output logic                   victimValid,
  output logic [PAGE_W-1:0]      victimPage,
  output logic [ENTRIES-1:0]     openMask
);
  tblCtl_t ctl;
  logic entryValid;
  logic pageMatch;
  logic [PAGE_W-1:0] storedPage;

  opt_ctrl #(.ROWS(ROWS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRow(reqRow),
    .rowPresent(rowPresent), .closeValid(closeValid), .flushValid(flushValid),
    .entryValid(entryValid), .pageMatch(pageMatch), .isHit(isHit),
    .isMiss(isMiss), .isEmpty(isEmpty), .reqError(reqError),
    .victimValid(victimValid), .ctl(ctl)
  );

  opt_datapath #(.ROWS(ROWS), .ADDR_W(ADDR_W), .MIN_PG_LOG2(MIN_PG_LOG2)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqRow(reqRow), .reqBank(reqBank),
    .reqAddr(reqAddr), .rowPageSize(rowPageSize), .closeRow(closeRow),
    .closeBank(closeBank), .flushRow(flushRow), .entryValid(entryValid),
    .pageMatch(pageMatch), .storedPage(storedPage), .openMask(openMask)
  );

  assign victimPage = victimValid ? storedPage : '0;

  // R3
  hit_keeps_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isHit && !closeValid && !flushValid) |=> $stable(openMask));

  // R6
  error_keeps_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqError && !closeValid && !flushValid) |=> $stable(openMask));
endmodule

// File: tb/sim_open_page_tracker.sv
`timescale 1ns/1ps
module sim_open_page_tracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqRow = '0, reqBank = '0;
  logic [31:0] reqAddr = '0;
  logic [7:0] rowPageSize = '0;
  logic [3:0] rowPresent = '0;
  logic closeValid = 1'b0;
  logic [1:0] closeRow = '0, closeBank = '0;
  logic flushValid = 1'b0;
  logic [1:0] flushRow = '0;
  logic isHit, isMiss, isEmpty, reqError, victimValid;
  logic [20:0] victimPage;
  logic [15:0] openMask;

  int nChecks = 0;
  int nFail = 0;
  bit refValid [16];
  logic [20:0] refPage [16];

  always #2.5 clk = ~clk;

  open_page_tracker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRow(reqRow),
    .reqBank(reqBank), .reqAddr(reqAddr), .rowPageSize(rowPageSize),
    .rowPresent(rowPresent), .closeValid(closeValid), .closeRow(closeRow),
    .closeBank(closeBank), .flushValid(flushValid), .flushRow(flushRow),
    .isHit(isHit), .isMiss(isMiss), .isEmpty(isEmpty), .reqError(reqError),
    .victimValid(victimValid), .victimPage(victimPage), .openMask(openMask)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [20:0] pageOf(input logic [31:0] a, input logic [1:0] r);
    logic [31:0] s;
    s = (a >> 11) >> rowPageSize[r*2 +: 2];
    return s[20:0];
  endfunction

  function automatic logic [15:0] refMask();
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = refValid[i];
    return m;
  endfunction

  task automatic doOp(input string tag, input bit rv, input logic [1:0] row,
                      input logic [1:0] bank, input logic [31:0] addr,
                      input bit cv, input logic [1:0] cRow, input logic [1:0] cBank,
                      input bit fv, input logic [1:0] fRow);
    int idx;
    bit eHit, eMiss, eEmpty, eErr;
    logic [20:0] pg, eVict;
    @(negedge clk);
    reqValid = rv; reqRow = row; reqBank = bank; reqAddr = addr;
    closeValid = cv; closeRow = cRow; closeBank = cBank;
    flushValid = fv; flushRow = fRow;
    #1;
    idx = {row, bank};
    pg = pageOf(addr, row);
    eHit = 0; eMiss = 0; eEmpty = 0; eErr = 0; eVict = '0;
    if (rv) begin
      if (!rowPresent[row]) eErr = 1;
      else if (!refValid[idx]) eEmpty = 1;
      else if (refPage[idx] == pg) eHit = 1;
      else begin eMiss = 1; eVict = refPage[idx]; end
    end
    chk({tag, " class R9"}, {isHit, isMiss, isEmpty, reqError}, {eHit, eMiss, eEmpty, eErr});
    chk({tag, " victim R4"}, {victimValid, victimPage}, {eMiss, eVict});
    @(posedge clk);
    if (cv) refValid[{cRow, cBank}] = 0;
    if (fv) for (int b = 0; b < 4; b++) refValid[{fRow, 2'(b)}] = 0;
    if (eEmpty || eMiss) begin refValid[idx] = 1; refPage[idx] = pg; end
    #1;
    chk({tag, " mask"}, openMask, refMask());
  endtask

  task automatic req(input string tag, input logic [1:0] row, input logic [1:0] bank,
                     input logic [31:0] addr);
    doOp(tag, 1, row, bank, addr, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < 16; i++) begin refValid[i] = 0; refPage[i] = '0; end
    rowPageSize = {2'd1, 2'd0, 2'd3, 2'd0};
    rowPresent = 4'b1011;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset mask", openMask, 16'h0);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 after release", openMask, 16'h0);

    // R2 empty, R3 hit, R4 miss in a 2 kB row
    req("R2 empty open", 0, 1, 32'h1000);
    chk("R2 bit set", openMask[1], 1'b1);
    req("R3 hit", 0, 1, 32'h1010);
    req("R4 miss", 0, 1, 32'h1800);
    req("R4 other bank empty", 0, 2, 32'h0);
    // R5: 16 kB row hit across 2 kB boundaries, 2 kB row misses
    req("R5 16k open", 1, 1, 32'h4000);
    req("R5 16k hit", 1, 1, 32'h7800);
    req("R5 2k miss", 0, 1, 32'h1000);
    req("R5 4k open", 3, 0, 32'h2000);
    req("R5 4k hit", 3, 0, 32'h2FFC);
    req("R5 4k miss", 3, 0, 32'h3000);
    // R6 unpopulated row
    req("R6 error", 2, 0, 32'h0);
    req("R6 error again", 2, 3, 32'h5000);
    // R7 single close, and close vs install on one entry
    req("R7 open b2", 3, 2, 32'h0);
    doOp("R7 close b0", 0, 0, 0, 0, 1, 3, 0, 0, 0);
    chk("R7 b2 kept", openMask[14], 1'b1);
    doOp("R7 close+install", 1, 3, 2, 32'h8000, 1, 3, 2, 0, 0);
    req("R7 installed page hit", 3, 2, 32'h8004);
    // R8 flush row, and flush with install in same row
    doOp("R8 flush row0", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 row0 clear", openMask[3:0], 4'h0);
    req("R8 row1 b0", 1, 0, 32'h0);
    doOp("R8 flush+install", 1, 1, 2, 32'hC000, 0, 0, 0, 1, 1);
    chk("R8 only b2", openMask[7:4], 4'b0100);
    // R9 idle
    doOp("R9 idle", 0, 1, 2, 32'hC000, 0, 0, 0, 0, 0);

    // random phase
    rowPageSize = 8'($urandom);
    for (int r = 0; r < 4; r++) doOp("R8 prep flush", 0, 0, 0, 0, 0, 0, 0, 1, 2'(r));
    for (int n = 0; n < 800; n++) begin
      bit rv, cv, fv;
      logic [31:0] a;
      rv = ($urandom % 8) != 0;
      cv = ($urandom % 8) == 0;
      fv = ($urandom % 20) == 0;
      a = (($urandom % 6) << 12) ^ ($urandom & 32'hFFF);
      doOp("R4 random", rv, 2'($urandom), 2'($urandom), a,
           cv, 2'($urandom), 2'($urandom), fv, 2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule